// File: doc/BRIEF.md
# Shared-Storage Window Address Decoder

This block sits in front of a bank of inter-thread communication cells. It holds two configuration registers that software reaches through a small tag port. From them it derives a storage window: where the window starts, whether it is open, and how large it is. Each access on the storage bus is tested against that window. An access that falls inside is split into a view code and a cell index, which the cell blocks downstream use to pick the cell and the operation.

The spacing between cells is programmable in powers of two, with 128 bytes as the smallest step. An index past the last cell selects the last cell. Accesses narrower than a word are refused with an error response, and a sticky status bit records them. A dedicated view reads that status word back, clears its error bits, and holds a small block-grain field.

Top module: `cu_window_decoder`

## Requirements
- R1: Config word 0 keeps the window base in bits 31:10 and the open flag in bit 0. A tag write at index 0 updates only those bits, and reading back gives the other bits as zero.
- R2: Config word 1 keeps a 7-bit mask in bits 16:10 and a 3-bit grain in bits 2:0. A tag write at index 1 updates only those bits. Bits 31:20 always read back the cell count.
- R3: The window size is (mask+1) KiB. A write takes effect only when that value is a power of two; any other value leaves the previous size in force.
- R4: `st_hit` is high only when `st_valid` is high, the open flag is set, and base <= `st_addr` < base + size.
- R5: `st_view` is bits 6:3 of the offset into the window. `st_cell` is the offset shifted right by 7 + grain.
- R6: A shifted index at or above NUM_CELLS yields `st_cell` = NUM_CELLS-1.
- R7: A hit with `st_size` below 2 (0 = byte, 1 = halfword) raises `st_err` in the same cycle. From the next cycle, status bit 2 is set.
- R8: A word read at view 15 returns the status word on `st_rdata`, with error bits in 2:0 and block grain in 10:8. A word write at view 15 clears each error bit written as 1 and loads bits 10:8 from the data.
- R9: After reset, word 0 reads 0 and word 1 reads (NUM_CELLS << 20) | 0xC00, which is a 4 KiB window with grain 0. The status word reads 0.
- R10: A tag read at an index above 1 returns 0. A tag write there changes no register and pulses `tag_bad` for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tag_wr | input | 1 | Config register write strobe |
| tag_idx | input | 3 | Config register index |
| tag_wdata | input | 32 | Config write data |
| tag_rdata | output | 32 | Config read data (combinational) |
| tag_bad | output | 1 | One-cycle flag after a write to an unmapped index |
| st_valid | input | 1 | Storage access present |
| st_write | input | 1 | Storage access is a write |
| st_size | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 double |
| st_addr | input | 32 | Storage byte address |
| st_wdata | input | 32 | Storage write data |
| st_hit | output | 1 | Access falls inside the open window |
| st_cell | output | $clog2(NUM_CELLS) | Selected cell, clamped |
| st_view | output | 4 | View code |
| st_err | output | 1 | Bus error response for a narrow access |
| st_rdata | output | 32 | Status word on a view-15 read, otherwise 0 |

## Verification
The assertions assume that the storage bus presents at most one access per cycle. They also assume that the inputs are steady across the clock edge, so an error bit is never set and cleared by the same access. The bench drives every input at the falling edge and holds it through exactly one rising edge. It never overlaps a narrow access with a status write. Tag writes are issued one at a time and released before the next.

// File: rtl/cu_window_decoder.sv
module cu_window_decoder #(
  parameter int NUM_CELLS = 32,
  parameter int TAG_IDX_W = 3,
  localparam int CELL_W = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tag_wr,
  input  logic [TAG_IDX_W-1:0] tag_idx,
  input  logic [31:0]       tag_wdata,
  output logic [31:0]       tag_rdata,
  output logic              tag_bad,
  input  logic              st_valid,
  input  logic              st_write,
  input  logic [1:0]        st_size,
  input  logic [31:0]       st_addr,
  input  logic [31:0]       st_wdata,
  output logic              st_hit,
  output logic [CELL_W-1:0] st_cell,
  output logic [3:0]        st_view,
  output logic              st_err,
  output logic [31:0]       st_rdata
);
  localparam int SIZE_W = 18;
  localparam int OFS_W  = 17;

  logic [21:0]       base_q;
  logic              en_q;
  logic [6:0]        mask_q;
  logic [2:0]        grain_q;
  logic [SIZE_W-1:0] size_q;
  logic [2:0]        err_q;
  logic [2:0]        blk_q;
  logic              tag_bad_q;

  logic [7:0]  mplus;
  logic        pow2;
  logic [32:0] win_lo, win_hi;
  logic [31:0] offset;
  logic [OFS_W-1:0] shifted;
  logic        word_ok, stat_view;
  logic [31:0] status;

  assign mplus  = {1'b0, tag_wdata[16:10]} + 8'd1;
  assign pow2   = (mplus & (mplus - 8'd1)) == 8'd0;

  assign win_lo = {1'b0, base_q, 10'b0};
  assign win_hi = win_lo + {15'b0, size_q};
  assign st_hit = st_valid && en_q && ({1'b0, st_addr} >= win_lo) && ({1'b0, st_addr} < win_hi);

  assign offset  = st_addr - {base_q, 10'b0};
  assign st_view = offset[6:3];
  assign shifted = offset[OFS_W-1:0] >> (5'd7 + {2'b0, grain_q});
  assign st_cell = (shifted >= OFS_W'(NUM_CELLS)) ? CELL_W'(NUM_CELLS - 1) : shifted[CELL_W-1:0];

  assign st_err    = st_hit && !st_size[1];
  assign word_ok   = st_hit && st_size[1];
  assign stat_view = st_view == 4'hF;
  assign status    = {21'b0, blk_q, 5'b0, err_q};
  assign st_rdata  = (word_ok && !st_write && stat_view) ? status : 32'b0;

  always_comb begin
    case (tag_idx)
      TAG_IDX_W'(0): tag_rdata = {base_q, 9'b0, en_q};
      TAG_IDX_W'(1): tag_rdata = {12'(NUM_CELLS), 3'b0, mask_q, 7'b0, grain_q};
      default:       tag_rdata = 32'b0;
    endcase
  end

  assign tag_bad = tag_bad_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q    <= '0;
      en_q      <= 1'b0;
      mask_q    <= 7'd3;
      grain_q   <= 3'd0;
      size_q    <= SIZE_W'(4096);
      err_q     <= '0;
      blk_q     <= '0;
      tag_bad_q <= 1'b0;
    end else begin
      tag_bad_q <= tag_wr && (tag_idx > TAG_IDX_W'(1));
      if (tag_wr && tag_idx == TAG_IDX_W'(0)) begin
        base_q <= tag_wdata[31:10];
        en_q   <= tag_wdata[0];
      end
      if (tag_wr && tag_idx == TAG_IDX_W'(1)) begin
        mask_q  <= tag_wdata[16:10];
        grain_q <= tag_wdata[2:0];
        if (pow2) size_q <= {mplus, 10'b0};
      end
      if (st_err) err_q[2] <= 1'b1;
      else if (word_ok && st_write && stat_view) begin
        err_q <= err_q & ~st_wdata[2:0];
        blk_q <= st_wdata[10:8];
      end
    end
  end
endmodule

module cu_window_decoder_chk #(
  parameter int NUM_CELLS = 32,
  parameter int TAG_IDX_W = 3,
  parameter int CELL_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tag_wr,
  input logic [TAG_IDX_W-1:0] tag_idx,
  input logic              tag_bad,
  input logic              st_valid,
  input logic [1:0]        st_size,
  input logic              st_hit,
  input logic              st_err,
  input logic [CELL_W-1:0] st_cell,
  input logic [17:0]       size_q,
  input logic              en_q,
  input logic [2:0]        err_q
);
  assert_size_pow2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(size_q) == 1);
  assert_hit_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st_hit |-> (en_q && st_valid));
  assert_cell_clamped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(st_cell) <= NUM_CELLS - 1);
  assert_err_narrow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st_err |-> (st_hit && !st_size[1]));
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st_err |=> err_q[2]);
  assert_bad_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tag_bad |-> ($past(tag_wr) && $past(tag_idx) > TAG_IDX_W'(1)));
endmodule

bind cu_window_decoder cu_window_decoder_chk #(
  .NUM_CELLS(NUM_CELLS), .TAG_IDX_W(TAG_IDX_W), .CELL_W(CELL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tag_wr(tag_wr), .tag_idx(tag_idx), .tag_bad(tag_bad),
  .st_valid(st_valid), .st_size(st_size), .st_hit(st_hit), .st_err(st_err),
  .st_cell(st_cell), .size_q(size_q), .en_q(en_q), .err_q(err_q)
);

// File: tb/sim_cu_window_decoder.sv
module sim_cu_window_decoder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tag_wr = 1'b0;
  logic [2:0] tag_idx = '0;
  logic [31:0] tag_wdata = '0, tag_rdata;
  logic tag_bad;
  logic st_valid = 1'b0, st_write = 1'b0;
  logic [1:0] st_size = 2'd2;
  logic [31:0] st_addr = '0, st_wdata = '0, st_rdata;
  logic st_hit, st_err;
  logic [4:0] st_cell;
  logic [3:0] st_view;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cu_window_decoder u0 (.*);

  localparam logic [41:0] VEC [6] = '{
    {32'h4000_0000, 1'b1, 5'd0,  4'd0},
    {32'h4000_0088, 1'b1, 5'd1,  4'd1},
    {32'h4000_0F78, 1'b1, 5'd30, 4'd15},
    {32'h4000_0FFF, 1'b1, 5'd31, 4'd15},
    {32'h4000_1000, 1'b0, 5'd0,  4'd0},
    {32'h3FFF_FFF8, 1'b0, 5'd0,  4'd0}
  };

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic twrite(logic [2:0] idx, logic [31:0] d);
    @(negedge clk); tag_wr = 1'b1; tag_idx = idx; tag_wdata = d;
    @(negedge clk); tag_wr = 1'b0;
  endtask

  task automatic tread(logic [2:0] idx, string req, logic [31:0] exp);
    @(negedge clk); tag_idx = idx; #1; chk(req, tag_rdata, exp);
  endtask

  task automatic drive(logic [31:0] a, logic [1:0] sz, logic wr, logic [31:0] d);
    @(negedge clk); st_valid = 1'b1; st_addr = a; st_size = sz; st_write = wr; st_wdata = d; #1;
  endtask

  task automatic release_bus();
    @(negedge clk); st_valid = 1'b0; st_write = 1'b0; st_size = 2'd2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tread(3'd0, "R9 word0", 32'h0);
    tread(3'd1, "R9 word1", 32'h0200_0C00);
    drive(32'h0000_0078, 2'd2, 1'b0, 0);
    chk("R4 closed window", {31'b0, st_hit}, 32'd0);
    release_bus();

    twrite(3'd0, 32'h4000_0001);
    tread(3'd0, "R1 base", 32'h4000_0001);
    drive(32'h4000_0078, 2'd2, 1'b0, 0);
    chk("R9 status", st_rdata, 32'h0);
    release_bus();

    for (int i = 0; i < 6; i++) begin
      drive(VEC[i][41:10], 2'd2, 1'b0, 0);
      chk("R4 hit", {31'b0, st_hit}, {31'b0, VEC[i][9]});
      if (VEC[i][9]) begin
        chk("R5 cell", {27'b0, st_cell}, {27'b0, VEC[i][8:4]});
        chk("R5 view", {28'b0, st_view}, {28'b0, VEC[i][3:0]});
      end
      release_bus();
    end

    twrite(3'd1, 32'h0000_0C02);
    tread(3'd1, "R2 grain", 32'h0200_0C02);
    drive(32'h4000_0600, 2'd2, 1'b0, 0);
    chk("R5 grain cell", {27'b0, st_cell}, 32'd3);
    release_bus();

    twrite(3'd1, 32'hFFFF_FFFF & 32'h0000_1C00);
    drive(32'h4000_1800, 2'd2, 1'b0, 0);
    chk("R6 clamp", {27'b0, st_cell}, 32'd31);
    chk("R3 grown hit", {31'b0, st_hit}, 32'd1);
    release_bus();
    twrite(3'd1, 32'h0000_0800);
    tread(3'd1, "R2 mask", 32'h0200_0800);
    drive(32'h4000_1FF8, 2'd2, 1'b0, 0);
    chk("R3 size kept", {31'b0, st_hit}, 32'd1);
    release_bus();
    drive(32'h4000_2000, 2'd2, 1'b0, 0);
    chk("R3 size kept end", {31'b0, st_hit}, 32'd0);
    release_bus();
    twrite(3'd1, 32'h0000_0C00);

    drive(32'h4000_0010, 2'd1, 1'b0, 0);
    chk("R7 err", {31'b0, st_err}, 32'd1);
    release_bus();
    drive(32'h4000_0010, 2'd2, 1'b0, 0);
    chk("R7 no err word", {31'b0, st_err}, 32'd0);
    release_bus();
    drive(32'h4000_0078, 2'd2, 1'b0, 0);
    chk("R7 status bit2", st_rdata, 32'h4);
    release_bus();
    drive(32'h4000_0078, 2'd2, 1'b1, 32'h0000_0504);
    release_bus();
    drive(32'h4000_0078, 2'd2, 1'b0, 0);
    chk("R8 status clear", st_rdata, 32'h500);
    release_bus();

    @(negedge clk); tag_wr = 1'b1; tag_idx = 3'd2; tag_wdata = 32'hFFFF_FFFF;
    @(negedge clk); tag_wr = 1'b0;
    chk("R10 bad pulse", {31'b0, tag_bad}, 32'd1);
    @(negedge clk);
    chk("R10 bad drop", {31'b0, tag_bad}, 32'd0);
    tread(3'd2, "R10 read zero", 32'h0);
    tread(3'd0, "R10 word0 kept", 32'h4000_0001);

    twrite(3'd0, 32'hFFFF_FFFF);
    tread(3'd0, "R1 masked", 32'hFFFF_FC01);
    twrite(3'd0, 32'h4000_0000);
    drive(32'h4000_0000, 2'd2, 1'b0, 0);
    chk("R4 disabled", {31'b0, st_hit}, 32'd0);
    release_bus();

    finish_run();
  end
endmodule